// File: doc/BRIEF.md
# Speculative Load Line Tracker

This block sits beside a data cache that two strands share. While a strand runs speculatively (execute-ahead, replay or a transaction), each of its loads leaves a mark on the cache line it read. The block keeps one mark bit per line for each strand. The marks let out-of-order or transactional loads appear ordered and atomic to other agents.

When the cache reports that a line is invalidated or evicted, every strand holding a mark on that line gets a one-cycle failure pulse. The strand's control logic then rolls back to its checkpoint. When a strand joins or abandons its speculation, a strobe wipes all of that strand's marks in one cycle and leaves the other strand's marks alone.

Cache tags, data arrays and the coherence protocol are outside this block. Only the line index of each access reaches it.

Top module: `spec_line_tracker`

## Requirements
- R1: After synchronous active-low reset, no strand holds any mark and `spec_fail` is 0; an invalidation of any line right after reset produces no pulse.
- R2: A load with `ld_valid`=1 and `ld_spec`=1 sets the mark of strand `ld_strand` for line `ld_line`, and a later invalidation of that line reports it.
- R3: When `inv_valid`=1 hits line L, bit s of `spec_fail` is 1 in the cycle after that edge exactly when strand s held a mark on L. The pulse lasts one cycle per invalidation event, and strands without a mark on L stay at 0.
- R4: A load with `ld_spec`=0 leaves no mark.
- R5: `join_strobe[s]` or `fail_strobe[s]` clears every mark of strand s in one cycle. The marks of the other strand are not changed.
- R6: An invalidation removes the mark of every strand on that line, so a second invalidation of the same line causes no pulse.
- R7: A speculative load and an invalidation of the same line in the same cycle make that strand's `spec_fail` bit pulse in the next cycle, and they leave no mark behind.
- R8: A clear strobe for strand s in the same cycle as a speculative load by s wins: no mark remains. An invalidation in that cycle still reports the marks held before the edge.
- R9: Lines 0 and NUM_LINES-1 are tracked like any other line, and a cycle with no invalidation never pulses `spec_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | A load accesses the cache this cycle |
| ld_line | input | LINE_W | Line index of the load |
| ld_strand | input | SID_W | Strand issuing the load |
| ld_spec | input | 1 | Issuing strand is speculative or in a transaction |
| inv_valid | input | 1 | A line is invalidated or evicted this cycle |
| inv_line | input | LINE_W | Line index being invalidated |
| join_strobe | input | NUM_STRANDS | Per-strand successful join, clears that strand's marks |
| fail_strobe | input | NUM_STRANDS | Per-strand abandoned speculation, clears that strand's marks |
| spec_fail | output | NUM_STRANDS | Per-strand registered failure pulse |

## Verification
Directed sequences set marks and then probe them through invalidations. They separate loads by strand, speculative loads from plain ones, a clear from an invalidation, and the line at each end of the index range. Same-cycle collisions tell apart the chosen priorities from the alternatives: a load meeting an invalidation, and a load meeting its strand's clear strobe. A long seeded random run then mixes loads, invalidations and strobes over a narrow band of lines. In that run, marks often overlap between strands, and each output cycle is compared with a bench-side model of the mark array.

// File: rtl/spec_trk_pkg.sv
// Package: shared helpers for the speculative load line tracker.
// Assumes nothing beyond integer parameters being positive.
package spec_trk_pkg;

    // Width needed to index n items, never less than one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/slt_onehot_dec.sv
// Module: slt_onehot_dec
// Turns an enable plus an index into a one-hot vector of N bits. The output is
// all zeros when disabled. Indices at or beyond N select nothing.
module slt_onehot_dec #(
    parameter int N = 64,
    parameter int W = 6
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] vec
);

    // One comparator per line: bit i is set when the index equals i.
    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam logic [W-1:0] MY_IDX = W'(i);
        assign vec[i] = en && (idx == MY_IDX);
    end

endmodule

// File: rtl/slt_mark_bank.sv
// Module: slt_mark_bank
// Holds the read marks of one strand, one bit per cache line. It raises a
// registered one-cycle fail pulse when an invalidation hits a marked line.
// Assumes: set_vec and inv_vec are one-hot or zero; clear wipes the bank and
// wins over a same-cycle set; an invalidation still reports marks held at
// the edge.
module slt_mark_bank #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_vec,
    input  logic                 inv_valid,
    input  logic [NUM_LINES-1:0] inv_vec,
    input  logic                 clear,
    output logic                 fail_pulse
);

    logic [NUM_LINES-1:0] marks_q;
    logic [NUM_LINES-1:0] marks_seen;
    logic [NUM_LINES-1:0] marks_d;
    logic                 hit;

    // Marks that count for this cycle: held bits plus a load landing now.
    assign marks_seen = marks_q | set_vec;

    // Hit when the invalidated line carries a mark, old or same-cycle.
    assign hit = inv_valid && (|(marks_seen & inv_vec));

    // Next marks: clear wins, otherwise add the load and drop the lost line.
    always_comb begin
        if (clear) begin
            marks_d = '0;
        end else if (inv_valid) begin
            marks_d = marks_seen & ~inv_vec;
        end else begin
            marks_d = marks_seen;
        end
    end

    // Mark storage and the registered fail pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marks_q    <= '0;
            fail_pulse <= 1'b0;
        end else begin
            marks_q    <= marks_d;
            fail_pulse <= hit;
        end
    end

    // R3: a pulse only follows a cycle that carried an invalidation.
    a_r3_fail_needs_inv: assert property (@(posedge clk) disable iff (!rst_n)
        fail_pulse |-> $past(inv_valid));

    // R5: after a clear strobe the bank is empty.
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (marks_q == '0));

    // R2: a set with no clear and no invalidation leaves the mark in place.
    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_vec) && !clear && !inv_valid) |=> (|(marks_q & $past(set_vec))));

    // R4: without a set, the number of marks never grows.
    a_r4_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !(|set_vec) |=> ($countones(marks_q) <= $past($countones(marks_q))));

    // R6: the invalidated line holds no mark afterwards.
    a_r6_line_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> (|(marks_q & $past(inv_vec))) == 1'b0);

endmodule

// File: rtl/spec_line_tracker.sv
// Module: spec_line_tracker (top)
// Tracks which cache lines each strand read while speculative, and pulses a
// per-strand failure when such a line is invalidated or evicted.
// Assumes: one load and one invalidation per cycle at most; strobes are
// per strand and may coincide with accesses.
module spec_line_tracker #(
    parameter int NUM_LINES   = 64,
    parameter int NUM_STRANDS = 2,
    parameter int LINE_W      = spec_trk_pkg::idx_width(NUM_LINES),
    parameter int SID_W       = spec_trk_pkg::idx_width(NUM_STRANDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_valid,
    input  logic [LINE_W-1:0]      ld_line,
    input  logic [SID_W-1:0]       ld_strand,
    input  logic                   ld_spec,
    input  logic                   inv_valid,
    input  logic [LINE_W-1:0]      inv_line,
    input  logic [NUM_STRANDS-1:0] join_strobe,
    input  logic [NUM_STRANDS-1:0] fail_strobe,
    output logic [NUM_STRANDS-1:0] spec_fail
);

    logic [NUM_LINES-1:0] ld_vec;
    logic [NUM_LINES-1:0] inv_vec;

    // Decode of the speculative load's line, shared by all strands.
    slt_onehot_dec #(.N(NUM_LINES), .W(LINE_W)) u_ld_dec (
        .en  (ld_valid && ld_spec),
        .idx (ld_line),
        .vec (ld_vec)
    );

    // Decode of the invalidated line, shared by all strands.
    slt_onehot_dec #(.N(NUM_LINES), .W(LINE_W)) u_inv_dec (
        .en  (inv_valid),
        .idx (inv_line),
        .vec (inv_vec)
    );

    // One independent mark bank per strand.
    for (genvar s = 0; s < NUM_STRANDS; s++) begin : g_strand
        localparam logic [SID_W-1:0] MY_ID = SID_W'(s);
        logic [NUM_LINES-1:0] set_vec;

        // Route the load's line to this strand only when it issued the load.
        assign set_vec = (ld_strand == MY_ID) ? ld_vec : '0;

        slt_mark_bank #(.NUM_LINES(NUM_LINES)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_vec    (set_vec),
            .inv_valid  (inv_valid),
            .inv_vec    (inv_vec),
            .clear      (join_strobe[s] || fail_strobe[s]),
            .fail_pulse (spec_fail[s])
        );
    end

    // R9: with no invalidation in the previous cycle, no strand pulses.
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!inv_valid) |-> (spec_fail == '0));

    // R7: a speculative load meeting an invalidation of its line fails its strand.
    a_r7_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_spec && inv_valid && (ld_line == inv_line))
            |=> (spec_fail[$past(ld_strand)] == 1'b1));

endmodule

// File: tb/spec_line_tracker_tb.sv
module spec_line_tracker_tb;

    localparam int NL = 64;
    localparam int NS = 2;
    localparam int LW = 6;
    localparam int SW = 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ld_valid;
    logic [LW-1:0] ld_line;
    logic [SW-1:0] ld_strand;
    logic          ld_spec;
    logic          inv_valid;
    logic [LW-1:0] inv_line;
    logic [NS-1:0] join_strobe;
    logic [NS-1:0] fail_strobe;
    logic [NS-1:0] spec_fail;

    bit [NL-1:0] mdl [NS];
    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    spec_line_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_line(ld_line),
        .ld_strand(ld_strand), .ld_spec(ld_spec), .inv_valid(inv_valid),
        .inv_line(inv_line), .join_strobe(join_strobe),
        .fail_strobe(fail_strobe), .spec_fail(spec_fail)
    );

    function automatic bit [NS-1:0] exp_fail(bit lv, int ll, int ls, bit sp,
                                             bit iv, int il);
        bit [NS-1:0] r = '0;
        for (int s = 0; s < NS; s++)
            r[s] = iv && (mdl[s][il] || (lv && sp && ls == s && ll == il));
        return r;
    endfunction

    task automatic check(string tag, bit [NS-1:0] exp);
        checks++;
        if (spec_fail !== exp) begin
            failures++;
            $display("FAIL %s spec_fail actual=%b expected=%b", tag, spec_fail, exp);
        end
    endtask

    task automatic step(bit lv, int ll, int ls, bit sp, bit iv, int il,
                        bit [NS-1:0] jn, bit [NS-1:0] fl, string tag);
        bit [NS-1:0] e;
        @(negedge clk);
        ld_valid = lv; ld_line = LW'(ll); ld_strand = SW'(ls); ld_spec = sp;
        inv_valid = iv; inv_line = LW'(il); join_strobe = jn; fail_strobe = fl;
        e = exp_fail(lv, ll, ls, sp, iv, il);
        for (int s = 0; s < NS; s++) begin
            if (jn[s] || fl[s]) mdl[s] = '0;
            else begin
                if (lv && sp && ls == s) mdl[s][ll] = 1'b1;
                if (iv) mdl[s][il] = 1'b0;
            end
        end
        @(posedge clk); #1;
        check(tag, e);
    endtask

    task automatic load(int l, int s, bit sp, string tag);
        step(1, l, s, sp, 0, 0, '0, '0, tag);
    endtask

    task automatic inval(int l, string tag);
        step(0, 0, 0, 0, 1, l, '0, '0, tag);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, 0, '0, '0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; ld_valid = 0; ld_line = '0; ld_strand = '0; ld_spec = 0;
        inv_valid = 0; inv_line = '0; join_strobe = '0; fail_strobe = '0;
        for (int s = 0; s < NS; s++) mdl[s] = '0;
        repeat (3) @(posedge clk);
        #1 check("R1 reset", '0);
        @(negedge clk) rst_n = 1'b1;

        // R1: nothing marked after reset
        inval(5, "R1 probe after reset");
        // R2 / R3: strand 0 mark on line 3, only strand 0 pulses
        load(3, 0, 1, "R2 load");
        inval(3, "R3 hit strand0");
        idle("R3 pulse one cycle");
        // R6: line already dropped
        inval(3, "R6 second inval");
        // R4: nonspeculative load
        load(10, 1, 0, "R4 nonspec load");
        inval(10, "R4 probe");
        // R5: clear strand 0 only
        load(7, 0, 1, "R5 load s0");
        load(7, 1, 1, "R5 load s1");
        load(8, 0, 1, "R5 load s0 b");
        step(0, 0, 0, 0, 0, 0, 2'b01, 2'b00, "R5 join s0");
        inval(7, "R5 s1 kept");
        inval(8, "R5 s0 cleared");
        load(9, 1, 1, "R5 load s1 c");
        step(0, 0, 0, 0, 0, 0, 2'b00, 2'b10, "R5 fail strobe s1");
        inval(9, "R5 s1 cleared");
        // R7: same-cycle load and invalidation
        step(1, 20, 1, 1, 1, 20, '0, '0, "R7 collide");
        inval(20, "R7 no leftover");
        // R8: clear beats same-cycle load; inval with clear reports old marks
        step(1, 30, 0, 1, 0, 0, '0, 2'b01, "R8 load with clear");
        inval(30, "R8 probe");
        load(31, 0, 1, "R8 load");
        step(0, 0, 0, 0, 1, 31, 2'b01, '0, "R8 inval with clear");
        // R9: edge lines, both strands
        load(0, 0, 1, "R9 line0");
        load(63, 1, 1, "R9 line63");
        load(63, 0, 1, "R9 line63 s0");
        inval(0, "R9 inval line0");
        inval(63, "R9 inval line63");
        idle("R9 idle");

        // Random mix on a narrow band of lines
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            bit [NS-1:0] jn = (r < 4) ? NS'($urandom_range(1, 3)) : '0;
            bit [NS-1:0] fl = (r >= 96) ? NS'($urandom_range(1, 3)) : '0;
            step($urandom_range(0, 3) != 0, $urandom_range(0, 11),
                 $urandom_range(0, 1), $urandom_range(0, 4) != 0,
                 $urandom_range(0, 2) == 0, $urandom_range(0, 11),
                 jn, fl, "R3 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule